// File: doc/BRIEF.md
# E1 Channel-Associated Signaling Inserter

The block places per-channel ABCD signaling into timeslot 16 of an outgoing E1 bit stream. A host writes sixteen 8-bit signaling registers through a simple write port. At every multiframe boundary the whole register set is copied into a shadow buffer in one cycle. The buffer then supplies one byte per frame, taken from timeslot 16, across the sixteen frames of the multiframe. If the host writes nothing, the same signaling goes out again in the next multiframe.

Bit and frame timing come from outside. A bit strobe comes with the bit index within the 256-bit frame and the frame index within the multiframe. The outgoing bit is registered: the value for a strobed bit appears on `tx_o` in the cycle after the strobe. A sticky flag marks each boundary so that the host knows when to refresh the registers, and a read of the flag clears it. With blocking mode on, a 30-bit mask chooses for each channel whether its nibble comes from the registers or is passed through from the serial input.

Top module: `cas_inserter`

## Requirements
- R1: After reset, register address 0 holds 8'h0B and addresses 1 to 15 hold 8'hFF. The shadow buffer holds the same values, so the first multiframe after reset sends them. `mf_flag_o` and `tx_o` are 0.
- R2: A register write takes effect in the shadow buffer only at the next multiframe boundary. A boundary is a strobe with frame index 0 and bit index 0. Data already in the current multiframe is unchanged by the write.
- R3: With no further writes, each following multiframe sends the same bytes again.
- R4: `mf_flag_o` goes to 1 in the cycle after each boundary strobe. A `flag_rd_i` pulse clears it in the next cycle. A read in the same cycle as a boundary strobe leaves it at 1.
- R5: In frame 0, bits 7..4 of the slot are always sent as 0000 whatever was written to address 0. Bits 3..0 are sent from address 0: bit 2 is the remote multiframe alarm and bits 3, 1 and 0 are spare.
- R6: Frame k (0..15) carries register address k in bit indices 128..135, MSB at index 128. For k from 1 to 15, bits 7..4 are A,B,C,D of channel k and bits 3..0 are A,B,C,D of channel k+15.
- R7: With `ins_en_i` at 0, every bit, timeslot 16 included, is sent as `ser_i`.
- R8: Outside bit indices 128..135, `tx_o` always equals the `ser_i` bit of the previous strobe.
- R9: With `blk_en_i` at 1, channel c uses mask bit c-1 of `blk_mask_i`. Mask bit 1 takes the channel's nibble from the registers and mask bit 0 passes the nibble from `ser_i`.
- R10: With `blk_en_i` at 0 the mask is ignored and all nibbles come from the registers. Frame 0 always comes from the registers while insertion is on.
- R11: A write that lands in the same cycle as a boundary strobe is not in the buffer loaded at that boundary. It goes out from the next multiframe on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit strobe |
| bit_idx_i | input | 8 | Bit index within the frame |
| frame_idx_i | input | 4 | Frame index within the multiframe |
| ser_i | input | 1 | Serial data input |
| ins_en_i | input | 1 | Signaling insertion enable |
| blk_en_i | input | 1 | Per-channel blocking mode enable |
| blk_mask_i | input | 30 | Per-channel source mask, bit c-1 for channel c |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| flag_rd_i | input | 1 | Flag read, clears the flag |
| mf_flag_o | output | 1 | Sticky multiframe boundary flag |
| tx_o | output | 1 | Serial data output |

## Verification
The assertions assume that the timing inputs are well formed: the bit index stays below 256, the frame index advances once per frame, and the insertion controls and mask hold steady between strobes. The path checks compare `tx_o` with the past `ser_i`, so they also rely on `bit_en_i` being high in the cycle they look back to. The stimulus meets all of this. It keeps `bit_en_i` high every cycle from a free-running bit and frame counter. It changes controls only at the negative edge just before a boundary, so every multiframe runs with a single setting.

// File: rtl/cas_pkg.sv
package cas_pkg;
  localparam int BYTE_W     = 8;
  localparam int N_REG      = 16;
  localparam int FRAME_BITS = 256;
  localparam int SLOT_IDX   = 16;
  localparam int N_CH       = 30;
  localparam logic [BYTE_W-1:0] RST_FIRST = 8'h0B;
  localparam logic [BYTE_W-1:0] RST_REST  = 8'hFF;
endpackage

// File: rtl/cas_sig_regs.sv
module cas_sig_regs #(
  parameter int N_REG  = cas_pkg::N_REG,
  parameter int BYTE_W = cas_pkg::BYTE_W,
  localparam int AW    = $clog2(N_REG)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [AW-1:0]                wr_addr_i,
  input  logic [BYTE_W-1:0]            wr_data_i,
  input  logic                         load_i,
  output logic [N_REG-1:0][BYTE_W-1:0] buf_o
);
  logic [N_REG-1:0][BYTE_W-1:0] reg_q;

  for (genvar i = 0; i < N_REG; i++) begin : g_reg
    localparam logic [BYTE_W-1:0] RV = (i == 0) ? cas_pkg::RST_FIRST : cas_pkg::RST_REST;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_q[i] <= RV;
        buf_o[i] <= RV;
      end else begin
        // shadow copy takes the pre-write value on a coincident write
        if (load_i) buf_o[i] <= reg_q[i];
        if (wr_en_i && wr_addr_i == AW'(i)) reg_q[i] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/cas_mf_flag.sv
module cas_mf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (rd_i)   flag_o <= 1'b0;
  end
endmodule

// File: rtl/cas_slot_mux.sv
module cas_slot_mux #(
  parameter int N_REG      = cas_pkg::N_REG,
  parameter int BYTE_W     = cas_pkg::BYTE_W,
  parameter int FRAME_BITS = cas_pkg::FRAME_BITS,
  parameter int SLOT_IDX   = cas_pkg::SLOT_IDX,
  parameter int N_CH       = cas_pkg::N_CH,
  localparam int BIT_W     = $clog2(FRAME_BITS),
  localparam int FW        = $clog2(N_REG),
  localparam int OFF_W     = $clog2(BYTE_W)
) (
  input  logic [BIT_W-1:0]             bit_idx_i,
  input  logic [FW-1:0]                frame_idx_i,
  input  logic                         ser_i,
  input  logic                         ins_en_i,
  input  logic                         blk_en_i,
  input  logic [N_CH-1:0]              blk_mask_i,
  input  logic [N_REG-1:0][BYTE_W-1:0] buf_i,
  output logic                         bit_o
);
  localparam int SLOT_LO = SLOT_IDX * BYTE_W;
  localparam int HALF    = BYTE_W / 2;

  logic              in_slot, upper, reg_src, mask_bit, buf_bit;
  logic [OFF_W-1:0]  off;
  logic [BYTE_W-1:0] byte_q;
  int                ch;

  always_comb begin
    in_slot  = (bit_idx_i >= BIT_W'(SLOT_LO)) && (bit_idx_i < BIT_W'(SLOT_LO + BYTE_W));
    off      = OFF_W'(bit_idx_i - BIT_W'(SLOT_LO));
    upper    = int'(off) < HALF;
    byte_q   = buf_i[frame_idx_i];
    buf_bit  = byte_q[BYTE_W-1-int'(off)];
    ch       = upper ? int'(frame_idx_i) - 1 : int'(frame_idx_i) - 2 + N_REG;
    mask_bit = (frame_idx_i != '0) && |(blk_mask_i & (N_CH'(1) << ch));
    reg_src  = (frame_idx_i == '0) || !blk_en_i || mask_bit;
    if (ins_en_i && in_slot && reg_src)
      bit_o = (frame_idx_i == '0 && upper) ? 1'b0 : buf_bit;  // alignment nibble
    else
      bit_o = ser_i;
  end
endmodule

// File: rtl/cas_inserter.sv
module cas_inserter #(
  parameter int N_REG      = cas_pkg::N_REG,
  parameter int BYTE_W     = cas_pkg::BYTE_W,
  parameter int FRAME_BITS = cas_pkg::FRAME_BITS,
  parameter int SLOT_IDX   = cas_pkg::SLOT_IDX,
  parameter int N_CH       = cas_pkg::N_CH,
  localparam int BIT_W     = $clog2(FRAME_BITS),
  localparam int FW        = $clog2(N_REG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic [FW-1:0]     frame_idx_i,
  input  logic              ser_i,
  input  logic              ins_en_i,
  input  logic              blk_en_i,
  input  logic [N_CH-1:0]   blk_mask_i,
  input  logic              wr_en_i,
  input  logic [FW-1:0]     wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              flag_rd_i,
  output logic              mf_flag_o,
  output logic              tx_o
);
  logic                         mf_start;
  logic                         mux_bit;
  logic [N_REG-1:0][BYTE_W-1:0] buf_q;

  assign mf_start = bit_en_i && bit_idx_i == '0 && frame_idx_i == '0;

  cas_sig_regs #(.N_REG(N_REG), .BYTE_W(BYTE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(mf_start), .buf_o(buf_q)
  );

  cas_mf_flag u_flag (
    .clk_i, .rst_ni, .set_i(mf_start), .rd_i(flag_rd_i), .flag_o(mf_flag_o)
  );

  cas_slot_mux #(
    .N_REG(N_REG), .BYTE_W(BYTE_W), .FRAME_BITS(FRAME_BITS),
    .SLOT_IDX(SLOT_IDX), .N_CH(N_CH)
  ) u_mux (
    .bit_idx_i, .frame_idx_i, .ser_i, .ins_en_i, .blk_en_i, .blk_mask_i,
    .buf_i(buf_q), .bit_o(mux_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_o <= 1'b0;
    else if (bit_en_i) tx_o <= mux_bit;
  end
endmodule

// File: rtl/cas_inserter_chk.sv
module cas_inserter_chk #(
  parameter int BIT_W = 8,
  parameter int FW    = 4,
  parameter int N_CH  = 30
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_en_i,
  input logic [BIT_W-1:0] bit_idx_i,
  input logic [FW-1:0]    frame_idx_i,
  input logic             ser_i,
  input logic             ins_en_i,
  input logic             blk_en_i,
  input logic [N_CH-1:0]  blk_mask_i,
  input logic             flag_rd_i,
  input logic             mf_flag_o,
  input logic             tx_o
);
  logic in_slot, bnd;
  assign in_slot = bit_idx_i >= BIT_W'(128) && bit_idx_i < BIT_W'(136);
  assign bnd     = bit_en_i && bit_idx_i == '0 && frame_idx_i == '0;

  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bnd |=> mf_flag_o);  // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_rd_i && !bnd) |=> !mf_flag_o);  // R4
  AST_ALIGN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && ins_en_i && frame_idx_i == '0 && bit_idx_i >= BIT_W'(128) && bit_idx_i < BIT_W'(132))
    |=> !tx_o);  // R5
  AST_PASS_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !ins_en_i) |=> tx_o == $past(ser_i));  // R7
  AST_PASS_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && !in_slot) |=> tx_o == $past(ser_i));  // R8
  AST_BLOCK_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_en_i && ins_en_i && blk_en_i && frame_idx_i != '0 && bit_idx_i >= BIT_W'(128)
     && bit_idx_i < BIT_W'(132) && !blk_mask_i[frame_idx_i - FW'(1)])
    |=> tx_o == $past(ser_i));  // R9
endmodule

bind cas_inserter cas_inserter_chk #(.BIT_W(BIT_W), .FW(FW), .N_CH(N_CH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_en_i(bit_en_i), .bit_idx_i(bit_idx_i),
  .frame_idx_i(frame_idx_i), .ser_i(ser_i), .ins_en_i(ins_en_i), .blk_en_i(blk_en_i),
  .blk_mask_i(blk_mask_i), .flag_rd_i(flag_rd_i), .mf_flag_o(mf_flag_o), .tx_o(tx_o)
);

// File: tb/cas_inserter_tb_top.sv
module cas_inserter_tb_top;
  logic        clk_i = 0, rst_ni = 0;
  logic        bit_en_i = 0, ser_i = 0, ins_en_i = 1, blk_en_i = 0;
  logic [7:0]  bit_idx_i = 0;
  logic [3:0]  frame_idx_i = 0;
  logic [29:0] blk_mask_i = '0;
  logic        wr_en_i = 0, flag_rd_i = 0;
  logic [3:0]  wr_addr_i = 0;
  logic [7:0]  wr_data_i = 0;
  logic        mf_flag_o, tx_o;

  cas_inserter dut_i (.*);

  always #5 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0, mf_count = 0, pass_err = 0;
  logic started = 0, run = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [7:0] model [16];
  logic [7:0] snap [16], done_exp [16];
  logic [7:0] cur_tx [16], cur_ser [16], done_tx [16], done_ser [16];
  logic snap_ins, snap_blk, done_ins, done_blk;
  logic [29:0] snap_mask, done_mask;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (started && bit_idx_i == 0 && frame_idx_i == 0) begin
      for (int i = 0; i < 16; i++) snap[i] = model[i];
      snap_ins = ins_en_i; snap_blk = blk_en_i; snap_mask = blk_mask_i;
    end
  end

  always @(negedge clk_i) begin
    if (run) begin
      if (!started) begin
        started = 1; bit_en_i = 1; bit_idx_i = 0; frame_idx_i = 0; ser_i = lfsr[0];
      end else begin
        if (bit_idx_i >= 128 && bit_idx_i < 136) begin
          cur_tx[frame_idx_i][7 - (bit_idx_i - 128)] = tx_o;
          cur_ser[frame_idx_i][7 - (bit_idx_i - 128)] = ser_i;
        end else if (tx_o !== ser_i) pass_err++;
        if (frame_idx_i == 15 && bit_idx_i == 255) begin
          for (int i = 0; i < 16; i++) begin
            done_tx[i] = cur_tx[i]; done_ser[i] = cur_ser[i]; done_exp[i] = snap[i];
          end
          done_ins = snap_ins; done_blk = snap_blk; done_mask = snap_mask;
          mf_count++;
        end
        if (bit_idx_i == 255) frame_idx_i = frame_idx_i + 1;
        bit_idx_i = bit_idx_i + 1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ser_i = lfsr[0];
      end
    end
  end

  task automatic sync_mf();
    @(mf_count);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i); @(negedge clk_i);
    model[a] = d; wr_en_i = 0;
  endtask

  function automatic logic [7:0] exp_byte(int k);
    logic [7:0] r, s, e;
    r = done_exp[k]; s = done_ser[k];
    if (!done_ins) return s;
    if (k == 0) return {4'b0000, r[3:0]};
    e[7:4] = (!done_blk || done_mask[k-1])  ? r[7:4] : s[7:4];
    e[3:0] = (!done_blk || done_mask[k+14]) ? r[3:0] : s[3:0];
    return e;
  endfunction

  task automatic check_mf(string tag);
    for (int k = 0; k < 16; k++) chk(tag, done_tx[k], exp_byte(k));
    chk("R8 pass-through outside slot", pass_err, 0);
  endtask

  task automatic t_reset();
    chk("R1 flag after reset", mf_flag_o, 0);
    chk("R1 tx after reset", tx_o, 0);
    sync_mf();
    chk("R1 first byte", done_tx[0], 8'h0B);
    for (int k = 1; k < 16; k++) chk("R1 rest bytes", done_tx[k], 8'hFF);
  endtask

  task automatic t_update();
    sync_mf();
    repeat (300) @(negedge clk_i);
    wr(0, 8'hF4);  // R5: upper nibble must not go out, alarm bit set
    for (int k = 1; k < 16; k++) wr(k[3:0], {k[3:0], ~k[3:0]});
    sync_mf();
    check_mf("R2 old data kept in current multiframe");
    chk("R2 frame 5 unchanged", done_tx[5], 8'hFF);
    sync_mf();
    check_mf("R6 mapping");
    chk("R5 alignment nibble forced", done_tx[0], 8'h04);
    chk("R6 frame 9 byte", done_tx[9], 8'h96);
    sync_mf();
    check_mf("R3 retransmit");
    chk("R3 frame 3 byte", done_tx[3], 8'h3C);
  endtask

  task automatic t_flag();
    sync_mf();
    repeat (10) @(negedge clk_i);
    flag_rd_i = 1; @(negedge clk_i); flag_rd_i = 0;
    chk("R4 cleared by read", mf_flag_o, 0);
    sync_mf();
    chk("R4 still clear before boundary", mf_flag_o, 0);
    @(negedge clk_i);
    chk("R4 set at boundary", mf_flag_o, 1);
    sync_mf();
    flag_rd_i = 1; @(negedge clk_i); flag_rd_i = 0;
    chk("R4 set wins over read", mf_flag_o, 1);
  endtask

  task automatic t_disable();
    sync_mf();
    ins_en_i = 0;
    sync_mf();
    check_mf("R7 insertion off");
    chk("R7 frame 7 is serial", done_tx[7], done_ser[7]);
    ins_en_i = 1;
  endtask

  task automatic t_block();
    sync_mf();
    blk_en_i = 1; blk_mask_i = 30'h2AAA_5555;
    sync_mf();
    check_mf("R9 blocking mask");
    chk("R9 ch1 mask 1 from reg", done_tx[1][7:4], 4'h1);
    chk("R9 ch16 mask 0 from serial", done_tx[1][3:0], done_ser[1][3:0]);
    blk_mask_i = '0;
    sync_mf();
    check_mf("R10 frame 0 from regs under full block");
    chk("R10 frame 0", done_tx[0], 8'h04);
    blk_en_i = 0;
    sync_mf();
    check_mf("R10 mask ignored when blocking off");
  endtask

  task automatic t_edge_write();
    sync_mf();
    wr(4'd2, 8'hA5);  // lands on the boundary cycle
    sync_mf();
    chk("R11 coincident write not loaded", done_tx[2], 8'h2D);
    sync_mf();
    chk("R11 coincident write next multiframe", done_tx[2], 8'hA5);
  endtask

  initial begin
    model[0] = 8'h0B;
    for (int i = 1; i < 16; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(posedge clk_i);
    run = 1;
    @(negedge clk_i);
    t_reset();
    t_update();
    t_flag();
    t_disable();
    t_block();
    t_edge_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule